// File: doc/BRIEF.md
# Calendar Nibble Register File

This block stores the time, date and control fields of a calendar clock and presents them to a host as sixteen 4-bit registers. Each address packs one or more fields into its nibble. A write splits the nibble back into those fields. Some writes change fields at other addresses. Reading the status address clears the pending interrupt flag.

Read data is combinational from the address. Writes take effect at the rising clock edge on which the write strobe is high. Two event inputs let a neighbouring time-keeping block raise the interrupt flag and the resync flag. Time counting and interrupt timing are not part of this block. A host-reset pulse clears the resync, pause and test flags and leaves the calendar alone.

Top module: `rtc_nibble_regfile`

## Requirements
- R1: After the asynchronous reset, every address reads 0 except address 1, which reads 0x8 (the battery-fail bit, bit 3, is set).
- R2: Addresses 0, 2, 4, 6, 8, 10 and 11 store the full written nibble and read it back unchanged, starting from the cycle after the write.
- R3: The packed addresses split writes into their fields and rebuild them on read. Address 1 holds seconds tens in bits 2:0 and battery-fail in bit 3. Address 3 holds minute tens in bits 2:0. Address 7 holds day tens in bits 1:0 and a spare field in bits 3:2. Address 9 holds month tens in bit 0 and a 3-bit spare field in bits 3:1. Address 12 holds the weekday in bits 2:0. Address 13 holds hold in bit 0, calendar in bit 1 and round-seconds in bit 3. Address 14 holds mask in bit 0, duty in bit 1 and period in bits 3:2. Address 15 holds pause, stop, 24-hour select and test in bits 0 to 3. On addresses 3 and 12, bit 3 of a write is discarded.
- R4: Address 5 holds hour tens and the meridian flag (bit 2). When 24-hour select is 0, a write stores only bit 0 of hour tens and stores bit 2 as the meridian.
- R5: When 24-hour select is 1, a write to address 5 stores hour tens from bits 1:0 and clears the meridian. A write to address 15 with bit 2 set clears the meridian. A write to address 15 with bit 2 clear masks hour tens down to bit 0.
- R6: A write to address 15 with bit 0 (pause) set clears the seconds units and the seconds tens in the same edge. A write with pause clear leaves both unchanged.
- R7: Bit 2 of address 13 is the interrupt flag ANDed with NOT mask. A read strobe on address 13 returns the value from before the clear, then clears the flag. An interrupt event in the same cycle wins over the clear. Reading address 13 without the strobe clears nothing.
- R8: While the mask is 1, bit 2 of address 13 reads 0 and the flag is kept. Clearing the mask shows the flag again.
- R9: Bit 3 of addresses 3, 5, 7, 9 and 12 shows the resync flag, ORed with any stored bit in that position. The resync event sets the flag. Address 11 does not show it.
- R10: A host-reset pulse clears resync, pause and test. It wins over a write in the same cycle and leaves stop and 24-hour select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| addr_i | input | 4 | Register address for both read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 4 | Write nibble |
| rd_en_i | input | 1 | Read strobe; carries the read side effects |
| rd_data_o | output | 4 | Combinational read nibble |
| irq_set_i | input | 1 | Event that sets the interrupt flag |
| resync_set_i | input | 1 | Event that sets the resync flag |
| host_rst_i | input | 1 | Host-reset pulse |

## Verification
The bench goes after the cross-field effects of the mode rules. If the 12/24-hour rule were applied only on writes to address 5, switching modes would leave a stale meridian or a 2-bit hour tens visible at address 5. The bench also checks the order of the read clear. A design that cleared the interrupt flag before driving the read data would lose the pending bit on the strobed read. A design that let the clear win over a same-cycle event would drop an interrupt. Other targets are the resync mirror, the masked flag, and pause-cleared seconds. A resync mirror missing from one address shows up as a wrong bit 3. A mask that discarded the flag, instead of hiding it, would not show it again after unmasking. Seconds that survived a pause write would read back non-zero.

// File: rtl/rtc_nib_pkg.sv
package rtc_nib_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_SEC_LO = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC_HI = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN_LO = 4'd2;
  localparam logic [ADDR_W-1:0] A_MIN_HI = 4'd3;
  localparam logic [ADDR_W-1:0] A_HR_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_HR_HI  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DAY_LO = 4'd6;
  localparam logic [ADDR_W-1:0] A_DAY_HI = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_MON_HI = 4'd9;
  localparam logic [ADDR_W-1:0] A_YR_LO  = 4'd10;
  localparam logic [ADDR_W-1:0] A_YR_HI  = 4'd11;
  localparam logic [ADDR_W-1:0] A_WDAY   = 4'd12;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd13;
  localparam logic [ADDR_W-1:0] A_IRQC   = 4'd14;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd15;

  typedef struct packed {
    logic [3:0] sec_lo;
    logic [2:0] sec_hi;
    logic       batt_fail;
    logic [3:0] min_lo;
    logic [2:0] min_hi;
    logic       resync;
    logic [3:0] hr_lo;
    logic [1:0] hr_hi;
    logic       merid;
    logic [3:0] day_lo;
    logic [1:0] day_hi;
    logic [1:0] day_spare;
    logic [3:0] mon_lo;
    logic       mon_hi;
    logic [2:0] mon_spare;
    logic [3:0] yr_lo;
    logic [3:0] yr_hi;
    logic [2:0] wday;
    logic       hold;
    logic       cal;
    logic       irq_flag;
    logic       round_sec;
    logic       irq_mask;
    logic       irq_duty;
    logic [1:0] irq_per;
    logic       pause;
    logic       stop;
    logic       h24;
    logic       test;
  } fields_t;

  localparam fields_t FIELDS_POR = '{batt_fail: 1'b1, default: '0};
endpackage

// File: rtl/rtc_nib_store.sv
module rtc_nib_store
  import rtc_nib_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  fields_t nxt_i,
  output fields_t cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= FIELDS_POR;
    else         cur_o <= nxt_i;
  end
endmodule

// File: rtl/rtc_nib_wr.sv
module rtc_nib_wr
  import rtc_nib_pkg::*;
(
  input  fields_t           cur_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic              irq_set_i,
  input  logic              resync_set_i,
  input  logic              host_rst_i,
  output fields_t           nxt_o
);
  logic [NIB_W-1:0] d;
  assign d = wr_data_i;

  always_comb begin
    nxt_o = cur_i;
    if (wr_en_i) begin
      unique case (addr_i)
        A_SEC_LO: nxt_o.sec_lo = d;
        A_SEC_HI: begin
          nxt_o.sec_hi    = d[2:0];
          nxt_o.batt_fail = d[3];
        end
        A_MIN_LO: nxt_o.min_lo = d;
        A_MIN_HI: nxt_o.min_hi = d[2:0];
        A_HR_LO:  nxt_o.hr_lo = d;
        A_HR_HI: begin
          if (cur_i.h24) begin
            nxt_o.hr_hi = d[1:0];
            nxt_o.merid = 1'b0;
          end else begin
            nxt_o.hr_hi = {1'b0, d[0]};
            nxt_o.merid = d[2];
          end
        end
        A_DAY_LO: nxt_o.day_lo = d;
        A_DAY_HI: begin
          nxt_o.day_hi    = d[1:0];
          nxt_o.day_spare = d[3:2];
        end
        A_MON_LO: nxt_o.mon_lo = d;
        A_MON_HI: begin
          nxt_o.mon_hi    = d[0];
          nxt_o.mon_spare = d[3:1];
        end
        A_YR_LO: nxt_o.yr_lo = d;
        A_YR_HI: nxt_o.yr_hi = d;
        A_WDAY:  nxt_o.wday  = d[2:0];
        A_STAT: begin
          nxt_o.hold      = d[0];
          nxt_o.cal       = d[1];
          nxt_o.round_sec = d[3];
        end
        A_IRQC: begin
          nxt_o.irq_mask = d[0];
          nxt_o.irq_duty = d[1];
          nxt_o.irq_per  = d[3:2];
        end
        default: begin
          nxt_o.pause = d[0];
          nxt_o.stop  = d[1];
          nxt_o.h24   = d[2];
          nxt_o.test  = d[3];
          if (d[2]) nxt_o.merid = 1'b0;
          else      nxt_o.hr_hi[1] = 1'b0;
          if (d[0]) begin
            nxt_o.sec_lo = '0;
            nxt_o.sec_hi = '0;
          end
        end
      endcase
    end
    // read side effect, then events (event wins over clear)
    if (rd_en_i && addr_i == A_STAT) nxt_o.irq_flag = 1'b0;
    if (irq_set_i)                   nxt_o.irq_flag = 1'b1;
    if (resync_set_i)                nxt_o.resync   = 1'b1;
    if (host_rst_i) begin
      nxt_o.resync = 1'b0;
      nxt_o.pause  = 1'b0;
      nxt_o.test   = 1'b0;
    end
  end
endmodule

// File: rtl/rtc_nib_rd.sv
module rtc_nib_rd
  import rtc_nib_pkg::*;
(
  input  fields_t           cur_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NIB_W-1:0]  rd_data_o
);
  logic       rs;
  logic       pend;
  assign rs   = cur_i.resync;
  assign pend = cur_i.irq_flag & ~cur_i.irq_mask;

  always_comb begin
    unique case (addr_i)
      A_SEC_LO: rd_data_o = cur_i.sec_lo;
      A_SEC_HI: rd_data_o = {cur_i.batt_fail, cur_i.sec_hi};
      A_MIN_LO: rd_data_o = cur_i.min_lo;
      A_MIN_HI: rd_data_o = {rs, cur_i.min_hi};
      A_HR_LO:  rd_data_o = cur_i.hr_lo;
      A_HR_HI:  rd_data_o = {rs, cur_i.merid, cur_i.hr_hi};
      A_DAY_LO: rd_data_o = cur_i.day_lo;
      A_DAY_HI: rd_data_o = {cur_i.day_spare[1] | rs, cur_i.day_spare[0], cur_i.day_hi};
      A_MON_LO: rd_data_o = cur_i.mon_lo;
      A_MON_HI: rd_data_o = {cur_i.mon_spare[2] | rs, cur_i.mon_spare[1:0], cur_i.mon_hi};
      A_YR_LO:  rd_data_o = cur_i.yr_lo;
      A_YR_HI:  rd_data_o = cur_i.yr_hi;
      A_WDAY:   rd_data_o = {rs, cur_i.wday};
      A_STAT:   rd_data_o = {cur_i.round_sec, pend, cur_i.cal, cur_i.hold};
      A_IRQC:   rd_data_o = {cur_i.irq_per, cur_i.irq_duty, cur_i.irq_mask};
      default:  rd_data_o = {cur_i.test, cur_i.h24, cur_i.stop, cur_i.pause};
    endcase
  end
endmodule

// File: rtl/rtc_nibble_regfile.sv
module rtc_nibble_regfile
  import rtc_nib_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  output logic [NIB_W-1:0]  rd_data_o,
  input  logic              irq_set_i,
  input  logic              resync_set_i,
  input  logic              host_rst_i
);
  fields_t cur, nxt;

  rtc_nib_store u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .cur_o  (cur)
  );

  rtc_nib_wr u_wr (
    .cur_i        (cur),
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_en_i      (rd_en_i),
    .irq_set_i    (irq_set_i),
    .resync_set_i (resync_set_i),
    .host_rst_i   (host_rst_i),
    .nxt_o        (nxt)
  );

  rtc_nib_rd u_rd (
    .cur_i     (cur),
    .addr_i    (addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/rtc_nibble_regfile_chk.sv
module rtc_nibble_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] addr_i,
  input logic       wr_en_i,
  input logic [3:0] wr_data_i,
  input logic       rd_en_i,
  input logic [3:0] rd_data_o,
  input logic       irq_set_i,
  input logic       resync_set_i,
  input logic       host_rst_i
);
  logic plain_addr;
  assign plain_addr = (addr_i == 4'd0) || (addr_i == 4'd2) || (addr_i == 4'd4) ||
                      (addr_i == 4'd6) || (addr_i == 4'd8) || (addr_i == 4'd10) ||
                      (addr_i == 4'd11);

  // R2
  plain_rt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && plain_addr) && addr_i == $past(addr_i)) |-> rd_data_o == $past(wr_data_i));

  // R7
  irq_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_en_i && addr_i == 4'd13 && !irq_set_i) && addr_i == 4'd13) |-> !rd_data_o[2]);

  // R6
  pause_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && addr_i == 4'd15 && wr_data_i[0]) && addr_i == 4'd0) |-> rd_data_o == 4'd0);

  // R5
  h24_merid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && addr_i == 4'd15 && wr_data_i[2]) && addr_i == 4'd5) |-> !rd_data_o[2]);

  // R9
  resync_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(resync_set_i && !host_rst_i) &&
     (addr_i == 4'd3 || addr_i == 4'd5 || addr_i == 4'd7 || addr_i == 4'd9 || addr_i == 4'd12))
    |-> rd_data_o[3]);

  // R10
  host_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(host_rst_i) && addr_i == 4'd15) |-> (!rd_data_o[0] && !rd_data_o[3]));
endmodule

bind rtc_nibble_regfile rtc_nibble_regfile_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .irq_set_i    (irq_set_i),
  .resync_set_i (resync_set_i),
  .host_rst_i   (host_rst_i)
);

// File: tb/rtc_nibble_regfile_test.sv
`timescale 1ns/1ps
module rtc_nibble_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic       re = 1'b0;
  logic [3:0] rdata;
  logic       irq_set = 1'b0;
  logic       rs_set = 1'b0;
  logic       hrst = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_nibble_regfile uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .wr_en_i      (we),
    .wr_data_i    (wdata),
    .rd_en_i      (re),
    .rd_data_o    (rdata),
    .irq_set_i    (irq_set),
    .resync_set_i (rs_set),
    .host_rst_i   (hrst)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [3:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse(input bit i, input bit r, input bit h);
    @(negedge clk);
    irq_set = i; rs_set = r; hrst = h;
    @(negedge clk);
    irq_set = 1'b0; rs_set = 1'b0; hrst = 1'b0;
  endtask

  task automatic t_reset;
    logic [3:0] v;
    for (int a = 0; a < 16; a++) begin
      peek(a[3:0], v);
      chk("R1 reset value", v, (a == 1) ? 4'h8 : 4'h0);
    end
  endtask

  task automatic t_plain;
    logic [3:0] v;
    logic [3:0] al[7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd8, 4'd10, 4'd11};
    logic [3:0] dl[7] = '{4'h5, 4'h9, 4'h3, 4'h7, 4'h2, 4'h9, 4'h1};
    for (int i = 0; i < 7; i++) wr(al[i], dl[i]);
    for (int i = 0; i < 7; i++) begin
      peek(al[i], v);
      chk("R2 plain readback", v, dl[i]);
    end
  endtask

  task automatic t_packed;
    logic [3:0] v;
    wr(4'd1, 4'hF);  peek(4'd1, v);  chk("R3 addr1 full", v, 4'hF);
    wr(4'd1, 4'h2);  peek(4'd1, v);  chk("R3 addr1 batt clear", v, 4'h2);
    wr(4'd3, 4'hD);  peek(4'd3, v);  chk("R3 addr3 drop bit3", v, 4'h5);
    wr(4'd7, 4'hE);  peek(4'd7, v);  chk("R3 addr7 split", v, 4'hE);
    wr(4'd9, 4'hB);  peek(4'd9, v);  chk("R3 addr9 split", v, 4'hB);
    wr(4'd12, 4'hE); peek(4'd12, v); chk("R3 addr12 drop bit3", v, 4'h6);
    wr(4'd14, 4'hD); peek(4'd14, v); chk("R3 addr14", v, 4'hD);
    wr(4'd13, 4'hF); peek(4'd13, v); chk("R3 addr13 no pend bit", v, 4'hB);
    wr(4'd14, 4'h0);
  endtask

  task automatic t_hours;
    logic [3:0] v;
    wr(4'd15, 4'h0);
    wr(4'd5, 4'h7);  peek(4'd5, v);  chk("R4 12h hour write", v, 4'h5);
    wr(4'd15, 4'h4); peek(4'd5, v);  chk("R5 24h clears meridian", v, 4'h1);
    wr(4'd5, 4'h6);  peek(4'd5, v);  chk("R5 24h hour write", v, 4'h2);
    wr(4'd15, 4'h0); peek(4'd5, v);  chk("R5 12h masks hour tens", v, 4'h0);
  endtask

  task automatic t_pause;
    logic [3:0] v;
    wr(4'd0, 4'h9);
    wr(4'd1, 4'hD);
    wr(4'd15, 4'h1);
    peek(4'd0, v);  chk("R6 pause clears sec lo", v, 4'h0);
    peek(4'd1, v);  chk("R6 pause clears sec hi", v, 4'h8);
    peek(4'd15, v); chk("R6 ctrl readback", v, 4'h1);
    wr(4'd15, 4'h0);
    wr(4'd0, 4'h4);
    wr(4'd15, 4'h2);
    peek(4'd0, v);  chk("R6 no pause keeps sec", v, 4'h4);
    wr(4'd15, 4'h0);
  endtask

  task automatic t_irq;
    logic [3:0] v;
    pulse(1'b1, 1'b0, 1'b0);
    peek(4'd13, v); chk("R7 pending visible", {3'b0, v[2]}, 4'h1);
    peek(4'd13, v); chk("R7 peek does not clear", {3'b0, v[2]}, 4'h1);
    @(negedge clk); addr = 4'd13; re = 1'b1; #1;
    chk("R7 strobed read pre-clear value", {3'b0, rdata[2]}, 4'h1);
    @(negedge clk); re = 1'b0;
    peek(4'd13, v); chk("R7 cleared after read", {3'b0, v[2]}, 4'h0);
    @(negedge clk); addr = 4'd13; re = 1'b1; irq_set = 1'b1;
    @(negedge clk); re = 1'b0; irq_set = 1'b0;
    peek(4'd13, v); chk("R7 set wins over clear", {3'b0, v[2]}, 4'h1);
    wr(4'd14, 4'h1);
    peek(4'd13, v); chk("R8 masked hides pend", {3'b0, v[2]}, 4'h0);
    wr(4'd14, 4'h0);
    peek(4'd13, v); chk("R8 flag kept under mask", {3'b0, v[2]}, 4'h1);
  endtask

  task automatic t_resync;
    logic [3:0] v;
    logic [3:0] al[5] = '{4'd3, 4'd5, 4'd7, 4'd9, 4'd12};
    pulse(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      peek(al[i], v); chk("R9 resync mirrored", {3'b0, v[3]}, 4'h1);
    end
    peek(4'd11, v); chk("R9 addr11 unaffected", v, 4'h1);
    peek(4'd3, v);  chk("R9 addr3 low bits kept", {1'b0, v[2:0]}, 4'h5);
    pulse(1'b0, 1'b0, 1'b1);
    peek(4'd3, v);  chk("R10 resync cleared", {3'b0, v[3]}, 4'h0);
  endtask

  task automatic t_hrst;
    logic [3:0] v;
    wr(4'd15, 4'hE);
    peek(4'd15, v); chk("R10 ctrl set", v, 4'hE);
    wr(4'd15, 4'hF);
    pulse(1'b0, 1'b0, 1'b1);
    peek(4'd15, v); chk("R10 host reset keeps stop/h24", v, 4'h6);
    @(negedge clk); addr = 4'd15; wdata = 4'h9; we = 1'b1; hrst = 1'b1;
    @(negedge clk); we = 1'b0; hrst = 1'b0;
    peek(4'd15, v); chk("R10 reset wins over write", v, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_packed();
    t_hours();
    t_pause();
    t_irq();
    t_resync();
    t_hrst();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule